// File: doc/BRIEF.md
# Daisy-Chain SPI Register Target

This block is an SPI target meant to be strung in a chain of identical copies. All copies share the serial clock and one active-low select. Each copy feeds its serial output into the data input of the next copy. No copy has a device address. While a frame shifts in, the frame that the copy held before shifts out. After the host has clocked one frame per copy, every copy holds its own new frame.

When select returns high, each copy acts on the frame it holds. A frame has three parts: a command byte, a 16-bit field whose low 12 bits are a target address, and a data byte. The address is decoded into one of two port windows, each with two logical devices, or into a local register window. The copy then issues one read or one write on a simple internal register bus. For a read, the returned byte replaces the data byte of the held frame, so the host collects it during the next frame.

The serial pins are sampled in the system clock domain through a synchronizer of configurable depth. The output enable of the serial data line follows the select pin with no clock involved.

Top module: `spi_dc_chain_target`

## Requirements
- R1: `miso_oe` is 1 exactly while `ss_n` is 0, with no clock edge needed; while `ss_n` is 1 the serial output is released.
- R2: While `ss_n` is 1, toggling `sck` and `mosi` leaves the held frame unchanged. The next frame shows this on `miso`.
- R3: Frames are sent MSB first. `mosi` is taken on a rising `sck` edge and `miso` moves on a falling edge. During a frame, `miso` presents the previously held 32-bit frame, starting with bit 31.
- R4: A frame is acted on only after `ss_n` rises. With the default synchronizer depth of 2, `bus_req` is high for exactly one clock cycle: the cycle after the third rising `clk` edge following the `ss_n` rise. Acting on the frame is unaffected when the last falling `sck` edge coincides with the `ss_n` rise.
- R5: A frame of any length other than 32 `sck` cycles produces no bus request and no read load.
- R6: Frame bit 31 set means read and clear means write; the other command bits are ignored. The address is frame bits [19:8], and frame bits [23:20] are ignored. Address bits [11:8] select the window: 0 gives port 0 device 0, 1 gives port 0 device 1, 4 gives port 1 device 0, 5 gives port 1 device 1, and 8 gives the local registers. `bus_port`, `bus_dev` and `bus_local` show the window, and `bus_offset` is address bits [7:0].
- R7: An address outside the five windows issues no bus request. A read of such an address loads 0x00 into the data byte.
- R8: For a read, `bus_rdata` in the request cycle replaces frame bits [7:0]. Bits [31:8] are kept, and the next frame shifts out the result.
- R9: For a write, `bus_we` is 1 and `bus_wdata` equals frame bits [7:0]. The held frame is unchanged.
- R10: After reset the held frame is all zeros, `bus_req` is 0, and `miso_oe` reflects `ss_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock shared along the chain |
| ss_n | input | 1 | Active-low select shared along the chain |
| mosi | input | 1 | Serial data in, from the host or the previous copy |
| miso | output | 1 | Serial data out, to the next copy or the host |
| miso_oe | output | 1 | Output enable for `miso` |
| bus_req | output | 1 | One-cycle register bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_port | output | 1 | Port window selected |
| bus_dev | output | 1 | Logical device within the port |
| bus_local | output | 1 | Local register window selected |
| bus_offset | output | 8 | Register offset within the window |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the request cycle |

## Verification
Two functions can land in the same cycle: the final shift of a frame and the detection that select has been released. The bench provokes this by dropping `sck` and raising `ss_n` in the same time step, so that both edges pass through equal-depth synchronizers together. It then judges the outcome on two things. The bus request must still carry the fully shifted address and data, in the expected cycle. The data loaded by the read must appear in the bits shifted out on the following frame.

// File: rtl/spi_dc_pkg.sv
package spi_dc_pkg;

   typedef enum logic [2:0] {
      RGN_NONE  = 3'd0,
      RGN_P0D0  = 3'd1,
      RGN_P0D1  = 3'd2,
      RGN_P1D0  = 3'd3,
      RGN_P1D1  = 3'd4,
      RGN_LOCAL = 3'd5
   } region_e;

   // Upper window code values (address bits above the window offset)
   localparam logic [1:0] WIN_PORT0 = 2'b00;
   localparam logic [1:0] WIN_PORT1 = 2'b01;
   localparam logic [1:0] WIN_LOCAL = 2'b10;

endpackage

// File: rtl/spi_dc_sync.sv
module spi_dc_sync #(
   parameter int               WIDTH  = 1,
   parameter int               STAGES = 2,
   parameter logic [WIDTH-1:0] INIT   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end

         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_dc_shifter.sv
module spi_dc_shifter #(
   parameter int FRAME_W = 32,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               sample_en,
   input  logic               shift_en,
   input  logic               serial_in,
   input  logic               load_en,
   input  logic [DATA_W-1:0]  load_data,
   output logic [FRAME_W-1:0] frame,
   output logic               frame_ok,
   output logic               serial_out
);

   localparam int CNT_W   = $clog2(FRAME_W + 2);
   localparam int CNT_SAT = FRAME_W + 1;

   logic [FRAME_W-1:0] sr;
   logic               held_bit;
   logic [CNT_W-1:0]   edges;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_bit <= 1'b0;
      else if (sample_en) held_bit <= serial_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edges <= '0;
      end else if (frame_start) begin
         edges <= '0;
      end else if (shift_en && (edges != CNT_W'(CNT_SAT))) begin
         edges <= edges + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
      end else if (shift_en) begin
         sr <= {sr[FRAME_W-2:0], held_bit};
      end else if (load_en) begin
         sr[DATA_W-1:0] <= load_data;
      end
   end

   assign frame      = sr;
   assign frame_ok   = (edges == CNT_W'(FRAME_W));
   assign serial_out = sr[FRAME_W-1];

endmodule

// File: rtl/spi_dc_decode.sv
module spi_dc_decode
   import spi_dc_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int WIN_BITS = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);

   localparam int TOP_LSB = WIN_BITS + 2;

   logic [1:0] win_hi;
   logic       win_gap;
   logic       win_dev;

   assign win_hi  = addr[TOP_LSB +: 2];
   assign win_gap = addr[WIN_BITS + 1];
   assign win_dev = addr[WIN_BITS];

   always_comb begin
      region = RGN_NONE;
      if (!win_gap) begin
         unique case (win_hi)
            WIN_PORT0: region = win_dev ? RGN_P0D1 : RGN_P0D0;
            WIN_PORT1: region = win_dev ? RGN_P1D1 : RGN_P1D0;
            WIN_LOCAL: region = win_dev ? RGN_NONE : RGN_LOCAL;
            default:   region = RGN_NONE;
         endcase
      end
   end

endmodule

// File: rtl/spi_dc_chain_target.sv
module spi_dc_chain_target
   import spi_dc_pkg::*;
#(
   parameter int CMD_W       = 8,
   parameter int FIELD_W     = 16,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 12,
   parameter int WIN_BITS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sck,
   input  logic                ss_n,
   input  logic                mosi,
   output logic                miso,
   output logic                miso_oe,
   output logic                bus_req,
   output logic                bus_we,
   output logic                bus_port,
   output logic                bus_dev,
   output logic                bus_local,
   output logic [WIN_BITS-1:0] bus_offset,
   output logic [DATA_W-1:0]   bus_wdata,
   input  logic [DATA_W-1:0]   bus_rdata
);

   localparam int FRAME_W = CMD_W + FIELD_W + DATA_W;

   generate
      if (ADDR_W > FIELD_W) begin : g_bad_addr
         $error("address wider than its frame field");
      end
      if (ADDR_W != WIN_BITS + 4) begin : g_bad_win
         $error("window decode expects four bits above the offset");
      end
      if (SYNC_STAGES > 8) begin : g_bad_sync
         $error("synchronizer depth out of range");
      end
   endgenerate

   // Output enable follows select directly, no clock involved
   assign miso_oe = ~ss_n;

   logic [2:0] pins_s;
   logic       sck_s, ssn_s, mosi_s;
   logic       sck_q, ssn_q;

   spi_dc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck, ss_n, mosi}),
      .q     (pins_s)
   );

   assign {sck_s, ssn_s, mosi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         ssn_q <= 1'b1;
      end else begin
         sck_q <= sck_s;
         ssn_q <= ssn_s;
      end
   end

   logic sck_up, sck_dn, sel_begin, sel_end;
   assign sck_up    = sck_s & ~sck_q;
   assign sck_dn    = ~sck_s & sck_q;
   assign sel_begin = ~ssn_s & ssn_q;
   assign sel_end   = ssn_s & ~ssn_q;

   // Execute stage
   logic                pend;
   logic [FRAME_W-1:0]  frame;
   logic                frame_ok;
   logic                act;
   logic                is_read;
   logic [ADDR_W-1:0]   addr;
   region_e             region;
   logic                hit;
   logic                load_en;
   logic [DATA_W-1:0]   load_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= sel_end;
   end

   spi_dc_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (sel_begin),
      .sample_en   (sck_up & ~ssn_s),
      .shift_en    (sck_dn & ~ssn_q),
      .serial_in   (mosi_s),
      .load_en     (load_en),
      .load_data   (load_data),
      .frame       (frame),
      .frame_ok    (frame_ok),
      .serial_out  (miso)
   );

   assign is_read = frame[FRAME_W-1];
   assign addr    = frame[DATA_W +: ADDR_W];

   spi_dc_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
      .addr   (addr),
      .region (region)
   );

   assign hit       = (region != RGN_NONE);
   assign act       = pend & frame_ok;
   assign load_en   = act & is_read;
   assign load_data = hit ? bus_rdata : '0;

   assign bus_req    = act & hit;
   assign bus_we     = ~is_read;
   assign bus_port   = (region == RGN_P1D0) || (region == RGN_P1D1);
   assign bus_dev    = (region == RGN_P0D1) || (region == RGN_P1D1);
   assign bus_local  = (region == RGN_LOCAL);
   assign bus_offset = addr[WIN_BITS-1:0];
   assign bus_wdata  = frame[DATA_W-1:0];

endmodule

// File: rtl/spi_dc_chain_chk.sv
module spi_dc_chain_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic ss_n,
   input logic miso,
   input logic bus_req,
   input logic bus_port,
   input logic bus_dev,
   input logic bus_local
);

   logic [3:0] idle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idle_cnt <= '0;
      else if (!ss_n)              idle_cnt <= '0;
      else if (idle_cnt != 4'hF)   idle_cnt <= idle_cnt + 1'b1;
   end

   // R2: once select has been high long enough to cross the synchronizer, the output bit holds
   a_r2_idle_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cnt > 4'(SYNC_STAGES + 1)) |-> $stable(miso));

   // R4: a request is a single-cycle pulse
   a_r4_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> !bus_req);

   // R4: a request only happens with select released
   a_r4_req_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (ss_n && $past(ss_n)));

   // R6: the local window never also names a port or device
   a_r6_window_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !(bus_local && (bus_port || bus_dev)));

   // R10: no request while reset is held
   always @(posedge clk) begin
      if (!rst_n) a_r10_quiet_in_reset: assert (!bus_req);
   end

endmodule

bind spi_dc_chain_target spi_dc_chain_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ss_n      (ss_n),
   .miso      (miso),
   .bus_req   (bus_req),
   .bus_port  (bus_port),
   .bus_dev   (bus_dev),
   .bus_local (bus_local)
);

// File: tb/tb_spi_dc_chain_target.sv
module tb_spi_dc_chain_target;

   localparam int CLK_PERIOD = 10;
   localparam int PH         = 4;   // clk cycles per sck phase
   localparam int REQ_AT     = 4;   // negedge index of request after ss_n rise (2 sync stages)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0;
   logic       ss_n = 1'b1;
   logic       mosi = 1'b0;
   logic       miso, miso_oe, bus_req, bus_we, bus_port, bus_dev, bus_local;
   logic [7:0] bus_offset, bus_wdata, bus_rdata;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit req_window = 1'b0;

   logic [31:0] m_sr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] rd_val(logic p, logic d, logic l, logic [7:0] off);
      return off ^ {l, p, d, 5'h0B};
   endfunction

   assign bus_rdata = rd_val(bus_port, bus_dev, bus_local, bus_offset);

   spi_dc_chain_target dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .bus_req(bus_req), .bus_we(bus_we),
      .bus_port(bus_port), .bus_dev(bus_dev), .bus_local(bus_local),
      .bus_offset(bus_offset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // R1: output enable against select on every clock
   always @(negedge clk) begin
      if (rst_n && !done) chk(miso_oe === !ss_n, "R1", int'(miso_oe), int'(!ss_n));
      if (rst_n && !done && !req_window && bus_req)
         chk(1'b0, "R4 stray request", 1, 0);
   end

   // Decode model: returns hit and window flags
   task automatic model_decode(input logic [11:0] a, output bit hit,
                               output bit p, output bit d, output bit l);
      hit = 1; p = 0; d = 0; l = 0;
      case (a[11:8])
         4'h0: ;
         4'h1: d = 1;
         4'h4: p = 1;
         4'h5: begin p = 1; d = 1; end
         4'h8: l = 1;
         default: hit = 0;
      endcase
   endtask

   task automatic send(input logic [31:0] fr, input int nbits, input bit merge_end, input string tag);
      bit hit, p, d, l, ok;
      logic [11:0] a;
      logic [31:0] fr_held;
      ss_n = 1'b0;
      step(PH);
      for (int i = 0; i < nbits; i++) begin
         logic b;
         b = (i < 32) ? fr[31-i] : 1'b0;
         mosi = b;
         step(PH);
         @(negedge clk);
         chk(miso === m_sr[31], {"R3 ", tag}, int'(miso), int'(m_sr[31]));
         @(posedge clk); #1;
         sck = 1'b1;
         step(PH);
         if (merge_end && i == nbits - 1) begin
            sck  = 1'b0;
            ss_n = 1'b1;
         end else begin
            sck = 1'b0;
            step(PH);
         end
         m_sr = {m_sr[30:0], b};
      end
      ss_n = 1'b1;
      fr_held = m_sr;
      ok = (nbits == 32);
      a  = fr_held[19:8];
      model_decode(a, hit, p, d, l);
      req_window = 1'b1;
      for (int k = 1; k <= 6; k++) begin
         bit exp;
         @(negedge clk);
         exp = (k == REQ_AT) && ok && hit;
         chk(bus_req === exp, ok ? {"R4 ", tag} : {"R5 ", tag}, int'(bus_req), int'(exp));
         if (exp) begin
            chk(bus_we === !fr_held[31], "R6 we", int'(bus_we), int'(!fr_held[31]));
            chk({bus_port, bus_dev, bus_local} === {p, d, l}, "R6 window",
                int'({bus_port, bus_dev, bus_local}), int'({p, d, l}));
            chk(bus_offset === a[7:0], "R6 offset", int'(bus_offset), int'(a[7:0]));
            if (!fr_held[31])
               chk(bus_wdata === fr_held[7:0], "R9 wdata", int'(bus_wdata), int'(fr_held[7:0]));
         end
      end
      req_window = 1'b0;
      if (ok && fr_held[31])
         m_sr[7:0] = hit ? rd_val(p, d, l, a[7:0]) : 8'h00;
      @(posedge clk); #1;
      step(PH);
   endtask

   initial begin
      step(3);
      @(negedge clk);
      chk(bus_req === 1'b0, "R10 req", int'(bus_req), 0);
      chk(miso_oe === 1'b0, "R10 oe", int'(miso_oe), 0);
      rst_n = 1'b1;
      step(3);
      // R10: first frame shifts out zeros (checked against zeroed model)
      send({8'h00, 16'h0000, 8'h5A}, 32, 0, "R10 wr p0d0");
      send({8'h80, 16'h0137, 8'h00}, 32, 0, "R8 rd p0d1");
      send({8'h81, 16'hF4C2, 8'h11}, 32, 0, "R6 rd p1d0 upper ignored");
      send({8'h7F, 16'h05FF, 8'hC3}, 32, 0, "R9 wr p1d1");
      send({8'h80, 16'h08A5, 8'h00}, 32, 0, "R8 rd local");
      send({8'h80, 16'h0200, 8'hEE}, 32, 0, "R7 rd miss");
      send({8'h00, 16'h0C10, 8'h77}, 32, 0, "R7 wr miss");
      send({8'h80, 16'h0812, 8'h00}, 20, 0, "R5 short");
      send({8'h80, 16'h0011, 8'h00}, 33, 0, "R5 long");
      // R2: activity while deselected must not disturb the held frame
      for (int j = 0; j < 6; j++) begin
         sck = ~sck; mosi = ~mosi;
         step(PH);
      end
      sck = 1'b0;
      step(PH);
      send({8'h80, 16'h00F0, 8'h00}, 32, 1, "R4 merged end");
      send({8'h80, 16'h0501, 8'h00}, 32, 0, "R2 after idle");
      send({8'h00, 16'h0FFF, 8'h00}, 32, 0, "R8 drain");
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

endmodule